// File: doc/BRIEF.md
# Command Word Collector

This block is the front end of a device's command channel. Software writes an opcode to one write-only port and then a run of 32-bit payload words to a second write-only port. The block keeps the current opcode, fills a small word buffer in arrival order and counts the words. After every write it compares the bytes received with the payload size that the current opcode needs. Once that size is reached, it presents the opcode and the whole buffer with a one-cycle execute strobe and records the result code that the command logic returns in the same cycle.

Opcodes outside the valid range fall back to an idle code. The idle code needs no payload and always ends in failure, without raising a strobe. An opcode whose payload size is zero runs straight away on its opcode write. Between an opcode write and the completion of its command, the status register reads a "not enough data" code. What each command actually does is outside this block.

Top module: `cmdw_collector`

## Requirements
- R1: After reset the status output reads 0 (success), the overflow flag is 0 and no execute strobe is raised.
- R2: An opcode write takes the written value as the current opcode only if it is between 1 and 10 inclusive. Any other value, including 0 and every value of 11 or more, makes the current opcode the idle code 0.
- R3: Every opcode write clears the word counter and sets the status to 32'hFFFF_FFFE ("not enough data") at the clock edge that takes the write.
- R4: Each payload write stores its word at the position given by the counter and then increments the counter. Word i appears on exec_buf[32*i+31:32*i].
- R5: When the words received times 4 are at least the byte size that the current opcode requires, exec_vld is high for exactly one cycle, the cycle after the write that reached the size, with exec_op equal to the opcode. At the next edge the status takes exec_result.
- R6: Opcodes 2, 3, 6, 8 and 10 need no payload and execute on their opcode write. With the default parameters, opcode 1 needs 6 words, 4 needs 24, 5 needs 3, 7 needs 10 and 9 needs 4.
- R7: After execution the current opcode returns to idle and the counter clears, so the next payload write with no new opcode runs the idle code.
- R8: The idle code executes on any write that leaves it current. It raises no execute strobe and sets the status to 32'hFFFF_FFFF (failure) one cycle after that write.
- R9: A payload write that finds the buffer full is dropped and sets a sticky overflow flag, which only reset clears.
- R10: A write that arrives in the cycle in which a command executes is applied after that command completes. A payload write then starts the idle code, and an opcode write starts a new command with status "not enough data".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wr | input | 1 | Opcode port write strobe |
| op_wdata | input | 32 | Opcode value written |
| dat_wr | input | 1 | Payload port write strobe (ignored when op_wr is high) |
| dat_wdata | input | 32 | Payload word written |
| exec_result | input | 32 | Result code returned by the command logic while exec_vld is high |
| exec_vld | output | 1 | One-cycle execute strobe |
| exec_op | output | 4 | Opcode being executed |
| exec_buf | output | 32*BUF_WORDS | Collected payload words, word 0 in the low bits |
| cmd_status | output | 32 | Command status register |
| overflow | output | 1 | Sticky buffer overflow flag |

## Verification
The collector is driven with zero-length opcodes, opcodes that need several words, invalid and zero opcodes, and payload writes made with no command pending. These show apart firing on the opcode write, firing on the word threshold and falling back to idle failure. An opcode rewrite in the middle of a payload checks that the counter restarts and that the buffer is filled again from word 0. A write placed in the very execute cycle checks the order of completion and the new write. A second instance with a four-word buffer receives a six-word command, to show that the extra words are dropped, the overflow flag holds and the command never fires.

// File: rtl/cmdc_pkg.sv
// Package: shared opcode and status codes for the command word collector.
// Assumes opcodes fit in 4 bits and status codes are 32 bits wide.
package cmdc_pkg;

    localparam int OPW      = 4;
    localparam int OP_LIMIT = 11;   // first opcode value that is not valid

    typedef enum logic [OPW-1:0] {
        OP_IDLE    = 4'd0,
        OP_CONFIG  = 4'd1,
        OP_ISSUE   = 4'd2,
        OP_UNPLUG  = 4'd3,
        OP_RINGS   = 4'd4,
        OP_DEVRST  = 4'd5,
        OP_BUSRST  = 4'd6,
        OP_MSGRING = 4'd7,
        OP_ADPRST  = 4'd8,
        OP_ABORT   = 4'd9,
        OP_SPARE   = 4'd10
    } cmd_op_e;

    localparam logic [31:0] ST_OK    = 32'h0000_0000;
    localparam logic [31:0] ST_FAIL  = 32'hFFFF_FFFF;
    localparam logic [31:0] ST_SHORT = 32'hFFFF_FFFE;

endpackage

// File: rtl/cmdc_decode.sv
// Module: cmdc_decode
// Checks a written opcode value against the valid range and looks up the
// payload byte count that the current opcode needs. Purely combinational.
// Assumes word counts are given as parameters; zero-length opcodes need 0.
module cmdc_decode
    import cmdc_pkg::*;
#(
    parameter int CFG_WORDS    = 6,
    parameter int RINGS_WORDS  = 24,
    parameter int DEVRST_WORDS = 3,
    parameter int MSG_WORDS    = 10,
    parameter int ABORT_WORDS  = 4
) (
    input  logic [31:0] code_in,
    input  cmd_op_e     cur_op,
    output cmd_op_e     op_dec,
    output logic [31:0] need_bytes
);

    localparam logic [31:0] CFG_BYTES    = 32'(CFG_WORDS * 4);
    localparam logic [31:0] RINGS_BYTES  = 32'(RINGS_WORDS * 4);
    localparam logic [31:0] DEVRST_BYTES = 32'(DEVRST_WORDS * 4);
    localparam logic [31:0] MSG_BYTES    = 32'(MSG_WORDS * 4);
    localparam logic [31:0] ABORT_BYTES  = 32'(ABORT_WORDS * 4);

    // Range check: only values strictly between idle and the limit are kept.
    always_comb begin
        if (code_in > 32'd0 && code_in < 32'(OP_LIMIT))
            op_dec = cmd_op_e'(code_in[OPW-1:0]);
        else
            op_dec = OP_IDLE;
    end

    // Payload size lookup for the opcode currently being collected.
    always_comb begin
        case (cur_op)
            OP_CONFIG:  need_bytes = CFG_BYTES;
            OP_RINGS:   need_bytes = RINGS_BYTES;
            OP_DEVRST:  need_bytes = DEVRST_BYTES;
            OP_MSGRING: need_bytes = MSG_BYTES;
            OP_ABORT:   need_bytes = ABORT_BYTES;
            default:    need_bytes = 32'd0;
        endcase
    end

endmodule

// File: rtl/cmdc_wordbuf.sv
// Module: cmdc_wordbuf
// Payload word buffer with a fill counter and a sticky overflow flag.
// A restart (opcode write or command completion) rewinds the counter; a
// payload write in the same cycle as a completion lands in word 0.
// Assumes dat_take is already masked against opcode writes.
module cmdc_wordbuf #(
    parameter int DEPTH = 24,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  keep_word,
    input  logic                  dat_take,
    input  logic [31:0]           wdata,
    output logic [CW-1:0]         cnt,
    output logic [DEPTH*32-1:0]   words,
    output logic                  ovf
);

    logic [CW-1:0] idx;
    logic          full;
    logic          store;

    // Write position and full test after any rewind in this cycle.
    always_comb begin
        idx   = restart ? '0 : cnt;
        full  = (idx == CW'(DEPTH));
        store = dat_take && keep_word && !full;
    end

    // Counter: rewind on restart, advance on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (store)
            cnt <= idx + CW'(1);
        else if (restart)
            cnt <= '0;
    end

    // Sticky overflow: set when a word arrives with no room left.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (dat_take && full)
            ovf <= 1'b1;
    end

    // One register per buffer word, loaded when the write position matches.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[32*i +: 32] <= '0;
            else if (store && idx == CW'(i))
                words[32*i +: 32] <= wdata;
        end
    end

endmodule

// File: rtl/cmdc_ctrl.sv
// Module: cmdc_ctrl
// Holds the current opcode, the status register and the "write seen" flag
// that triggers the threshold check in the cycle after each write.
// Assumes need_bytes is the size for cur_op and cnt the words collected.
module cmdc_ctrl
    import cmdc_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_wr,
    input  cmd_op_e       op_dec,
    input  logic          dat_wr,
    input  logic [31:0]   need_bytes,
    input  logic [CW-1:0] cnt,
    input  logic [31:0]   exec_result,
    output cmd_op_e       cur_op,
    output logic          fire,
    output logic          exec_vld,
    output logic [31:0]   status
);

    logic        armed;
    logic [31:0] have_bytes;

    // Threshold check: runs once after every write.
    always_comb begin
        have_bytes = 32'(cnt) << 2;
        fire       = armed && (have_bytes >= need_bytes);
        exec_vld   = fire && (cur_op != OP_IDLE);
    end

    // Opcode, status and arm flag; a new opcode overrides a completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= OP_IDLE;
            armed  <= 1'b0;
            status <= ST_OK;
        end else if (op_wr) begin
            cur_op <= op_dec;
            armed  <= 1'b1;
            status <= ST_SHORT;
        end else begin
            if (fire) begin
                cur_op <= OP_IDLE;
                status <= (cur_op == OP_IDLE) ? ST_FAIL : exec_result;
            end
            armed <= dat_wr;
        end
    end

endmodule

// File: rtl/cmdw_collector.sv
// Module: cmdw_collector (top)
// Collects an opcode and its payload words from two write ports and fires a
// one-cycle execute strobe once the payload for that opcode is complete.
// Assumes at most one write per cycle; if both ports are written together
// the opcode write wins and the payload word is discarded.
module cmdw_collector
    import cmdc_pkg::*;
#(
    parameter int CFG_WORDS    = 6,
    parameter int RINGS_WORDS  = 24,
    parameter int DEVRST_WORDS = 3,
    parameter int MSG_WORDS    = 10,
    parameter int ABORT_WORDS  = 4,
    parameter int BUF_WORDS    = RINGS_WORDS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_wr,
    input  logic [31:0]            op_wdata,
    input  logic                   dat_wr,
    input  logic [31:0]            dat_wdata,
    input  logic [31:0]            exec_result,
    output logic                   exec_vld,
    output logic [OPW-1:0]         exec_op,
    output logic [BUF_WORDS*32-1:0] exec_buf,
    output logic [31:0]            cmd_status,
    output logic                   overflow
);

    localparam int CW = $clog2(BUF_WORDS + 1);

    cmd_op_e       op_dec;
    cmd_op_e       cur_op;
    logic [31:0]   need_bytes;
    logic [CW-1:0] cnt;
    logic          fire;
    logic          dat_take;
    logic          restart;

    // Port arbitration and buffer rewind control.
    always_comb begin
        dat_take = dat_wr && !op_wr;
        restart  = op_wr || fire;
    end

    cmdc_decode #(
        .CFG_WORDS    (CFG_WORDS),
        .RINGS_WORDS  (RINGS_WORDS),
        .DEVRST_WORDS (DEVRST_WORDS),
        .MSG_WORDS    (MSG_WORDS),
        .ABORT_WORDS  (ABORT_WORDS)
    ) u_dec (
        .code_in    (op_wdata),
        .cur_op     (cur_op),
        .op_dec     (op_dec),
        .need_bytes (need_bytes)
    );

    cmdc_wordbuf #(
        .DEPTH (BUF_WORDS),
        .CW    (CW)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .keep_word (1'b1),
        .dat_take  (dat_take),
        .wdata     (dat_wdata),
        .cnt       (cnt),
        .words     (exec_buf),
        .ovf       (overflow)
    );

    cmdc_ctrl #(
        .CW (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_wr       (op_wr),
        .op_dec      (op_dec),
        .dat_wr      (dat_wr),
        .need_bytes  (need_bytes),
        .cnt         (cnt),
        .exec_result (exec_result),
        .cur_op      (cur_op),
        .fire        (fire),
        .exec_vld    (exec_vld),
        .status      (cmd_status)
    );

    // Opcode presented alongside the strobe.
    always_comb exec_op = cur_op;

endmodule

// File: rtl/cmdw_collector_chk.sv
// Module: cmdw_collector_chk
// Port-level properties of the command word collector, bound to the top.
module cmdw_collector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_wr,
    input logic        dat_wr,
    input logic [31:0] exec_result,
    input logic        exec_vld,
    input logic [3:0]  exec_op,
    input logic [31:0] cmd_status,
    input logic        overflow
);

    // R2
    exec_op_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_vld |-> (exec_op >= 4'd1 && exec_op <= 4'd10));

    // R3
    short_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> (cmd_status == 32'hFFFF_FFFE));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && !op_wr) |=> !exec_vld);

    // R5
    result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && !op_wr) |=> (cmd_status == $past(exec_result)));

    // R9
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R10
    data_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_vld && dat_wr && !op_wr) |=> !exec_vld);

endmodule

bind cmdw_collector cmdw_collector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_wr       (op_wr),
    .dat_wr      (dat_wr),
    .exec_result (exec_result),
    .exec_vld    (exec_vld),
    .exec_op     (exec_op),
    .cmd_status  (cmd_status),
    .overflow    (overflow)
);

// File: tb/cmdw_collector_test.sv
module cmdw_collector_test;

    localparam int BW  = 24;
    localparam int SBW = 4;
    localparam logic [31:0] SHORT = 32'hFFFF_FFFE;
    localparam logic [31:0] FAIL_CODE = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        op_wr = 1'b0, dat_wr = 1'b0;
    logic [31:0] op_wdata = '0, dat_wdata = '0, res = 32'h0000_005A;
    logic        exec_vld, overflow;
    logic [3:0]  exec_op;
    logic [BW*32-1:0] exec_buf;
    logic [31:0] cmd_status;

    logic        s_op_wr = 1'b0, s_dat_wr = 1'b0;
    logic [31:0] s_op_wdata = '0, s_dat_wdata = '0;
    logic        s_exec_vld, s_overflow;
    logic [3:0]  s_exec_op;
    logic [SBW*32-1:0] s_exec_buf;
    logic [31:0] s_cmd_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmdw_collector uut (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_wdata(op_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .exec_result(res),
        .exec_vld(exec_vld), .exec_op(exec_op), .exec_buf(exec_buf),
        .cmd_status(cmd_status), .overflow(overflow)
    );

    cmdw_collector #(.BUF_WORDS(SBW)) uut_small (
        .clk(clk), .rst_n(rst_n), .op_wr(s_op_wr), .op_wdata(s_op_wdata),
        .dat_wr(s_dat_wr), .dat_wdata(s_dat_wdata), .exec_result(res),
        .exec_vld(s_exec_vld), .exec_op(s_exec_op), .exec_buf(s_exec_buf),
        .cmd_status(s_cmd_status), .overflow(s_overflow)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One opcode write; returns in the cycle after the taking edge.
    task automatic wr_op(logic [31:0] v);
        @(negedge clk); op_wr = 1'b1; op_wdata = v;
        @(negedge clk); op_wr = 1'b0;
    endtask

    task automatic wr_dat(logic [31:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", cmd_status, 32'h0);
        chk("R1 exec_vld", 32'(exec_vld), 32'd0);
        chk("R1 overflow", 32'(overflow), 32'd0);
    endtask

    task automatic t_zero_len;
        res = 32'h0000_005A;
        wr_op(32'd6);
        chk("R6 busrst strobe", 32'(exec_vld), 32'd1);
        chk("R5 busrst op", 32'(exec_op), 32'd6);
        chk("R3 status short", cmd_status, SHORT);
        @(negedge clk);
        chk("R5 status result", cmd_status, 32'h0000_005A);
        chk("R5 single pulse", 32'(exec_vld), 32'd0);
        res = 32'h0000_0011;
        wr_op(32'd10);
        chk("R6 op10 strobe", 32'(exec_vld), 32'd1);
        chk("R2 op10 kept", 32'(exec_op), 32'd10);
        @(negedge clk);
    endtask

    task automatic t_config;
        res = 32'h0000_0077;
        wr_op(32'd1);
        chk("R3 cfg short", cmd_status, SHORT);
        chk("R6 cfg no strobe", 32'(exec_vld), 32'd0);
        for (int i = 0; i < 5; i++) begin
            wr_dat(32'hC0DE_0000 + 32'(i));
            chk("R6 cfg waiting", 32'(exec_vld), 32'd0);
        end
        wr_dat(32'hC0DE_0005);
        chk("R5 cfg strobe", 32'(exec_vld), 32'd1);
        chk("R5 cfg op", 32'(exec_op), 32'd1);
        for (int i = 0; i < 6; i++)
            chk("R4 cfg word", exec_buf[32*i +: 32], 32'hC0DE_0000 + 32'(i));
        @(negedge clk);
        chk("R5 cfg status", cmd_status, 32'h0000_0077);
        chk("R7 cfg idle", 32'(exec_vld), 32'd0);
    endtask

    task automatic t_idle_paths;
        wr_op(32'd11);
        chk("R2 op11 no strobe", 32'(exec_vld), 32'd0);
        chk("R3 op11 short", cmd_status, SHORT);
        @(negedge clk);
        chk("R8 op11 fail", cmd_status, FAIL_CODE);
        wr_op(32'd0);
        chk("R2 op0 no strobe", 32'(exec_vld), 32'd0);
        @(negedge clk);
        chk("R8 op0 fail", cmd_status, FAIL_CODE);
        wr_op(32'd5);
        chk("R3 devrst short", cmd_status, SHORT);
        wr_op(32'h0000_0105);
        chk("R2 wide value idle", 32'(exec_vld), 32'd0);
        @(negedge clk);
        chk("R2 wide value fail", cmd_status, FAIL_CODE);
    endtask

    task automatic t_orphan_data;
        res = 32'h0000_0033;
        wr_op(32'd5);
        wr_dat(32'hA1); wr_dat(32'hA2); wr_dat(32'hA3);
        chk("R6 devrst strobe", 32'(exec_vld), 32'd1);
        chk("R4 devrst w2", exec_buf[64 +: 32], 32'hA3);
        @(negedge clk);
        chk("R5 devrst status", cmd_status, 32'h33);
        wr_dat(32'hBEEF);
        chk("R7 orphan no strobe", 32'(exec_vld), 32'd0);
        @(negedge clk);
        chk("R7 orphan fail", cmd_status, FAIL_CODE);
    endtask

    task automatic t_rewrite;
        res = 32'h0000_0044;
        wr_op(32'd1);
        wr_dat(32'h11); wr_dat(32'h12); wr_dat(32'h13);
        wr_op(32'd9);
        chk("R3 rewrite short", cmd_status, SHORT);
        for (int i = 0; i < 3; i++) begin
            wr_dat(32'h90 + 32'(i));
            chk("R3 abort waiting", 32'(exec_vld), 32'd0);
        end
        wr_dat(32'h93);
        chk("R3 abort strobe", 32'(exec_vld), 32'd1);
        chk("R3 abort op", 32'(exec_op), 32'd9);
        chk("R4 abort w0", exec_buf[31:0], 32'h90);
        chk("R4 abort w3", exec_buf[96 +: 32], 32'h93);
        @(negedge clk);
        chk("R5 abort status", cmd_status, 32'h44);
    endtask

    task automatic t_write_in_exec;
        res = 32'h0000_0066;
        @(negedge clk); op_wr = 1'b1; op_wdata = 32'd8;
        @(negedge clk); op_wr = 1'b0; dat_wr = 1'b1; dat_wdata = 32'h55;
        chk("R10 strobe", 32'(exec_vld), 32'd1);
        chk("R10 op", 32'(exec_op), 32'd8);
        @(negedge clk); dat_wr = 1'b0;
        chk("R10 result first", cmd_status, 32'h66);
        chk("R10 idle no strobe", 32'(exec_vld), 32'd0);
        @(negedge clk);
        chk("R10 then idle fail", cmd_status, FAIL_CODE);
        res = 32'h0000_0022;
        @(negedge clk); op_wr = 1'b1; op_wdata = 32'd2;
        @(negedge clk); op_wdata = 32'd7;
        chk("R10 op2 strobe", 32'(exec_vld), 32'd1);
        @(negedge clk); op_wr = 1'b0;
        chk("R10 op7 short", cmd_status, SHORT);
        chk("R10 op7 waits", 32'(exec_vld), 32'd0);
    endtask

    task automatic t_overflow;
        @(negedge clk); s_op_wr = 1'b1; s_op_wdata = 32'd1;
        @(negedge clk); s_op_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); s_dat_wr = 1'b1; s_dat_wdata = 32'(i);
            @(negedge clk); s_dat_wr = 1'b0;
        end
        chk("R9 full no ovf", 32'(s_overflow), 32'd0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); s_dat_wr = 1'b1; s_dat_wdata = 32'hEE;
            @(negedge clk); s_dat_wr = 1'b0;
            chk("R9 dropped no strobe", 32'(s_exec_vld), 32'd0);
        end
        chk("R9 ovf set", 32'(s_overflow), 32'd1);
        chk("R9 status short", s_cmd_status, SHORT);
        chk("R9 word3 kept", s_exec_buf[96 +: 32], 32'd3);
        @(negedge clk); s_op_wr = 1'b1; s_op_wdata = 32'd6;
        @(negedge clk); s_op_wr = 1'b0;
        chk("R9 ovf sticky", 32'(s_overflow), 32'd1);
        chk("R9 later cmd runs", 32'(s_exec_vld), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_len();
        t_config();
        t_idle_paths();
        t_orphan_data();
        t_rewrite();
        t_write_in_exec();
        t_overflow();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule